// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block controls the power state of the digital side of a high-speed data converter. It has three states: Normal, Nap and Sleep. After reset the state comes from a three-level mode-select pin. A write to one control register can later take over from the pin. Once that happens the pin is ignored until the next reset.

Entering a low-power state takes one clock edge. The output-enable falls on that edge, so the data, clock-out and over-range drivers go to high impedance. Leaving a low-power state passes through a recovery phase that is timed in input-clock cycles. Sleep recovery lasts one millisecond. Nap recovery is short. If the sample clock halted while in Nap, Nap recovery also waits for a lock strobe from the delay-locked loop. A ready flag is raised only when recovery is complete.

While in Sleep with the chip-select line high, the control port is closed. It opens again only after chip-select has been low for a fixed setup interval. The serial framing, analog power switches and the loop itself sit outside the block. They appear here as a write strobe with address and data, and as a one-cycle lock strobe.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst` is high on a clock edge, the state is loaded directly from the decoded `mode_pin`, with no recovery phase. The register override is cleared, and `cfg_accept` reads 1 after reset.
- R2: `mode_pin` is decoded as 00 = Normal, 01 = Nap, 10 = Sleep and 11 = Normal. From Normal, a target of Nap or Sleep is entered on the next edge. `ready` and `out_en` fall on that same edge.
- R3: `cur_mode` reports the state as 00 = Normal, 01 = Nap, 10 = Sleep and 11 = recovering. `out_en` is 0 in Nap and Sleep. A change of target between Nap and Sleep takes effect on the next edge.
- R4: A write to address `REG_ADDR` (default 25) decodes `wr_data[3:1]`: 001 = Normal, 010 = Nap, 011 = Sleep. `wr_data[0]` is ignored. An accepted write sets a sticky override, and `mode_pin` has no effect from then until reset. The FSM acts on a written mode one edge after the write edge.
- R5: Writes to any other address have no effect. So do writes to `REG_ADDR` whose field is 000 or 1xx.
- R6: Leaving Sleep enters recovery: `cur_mode` = 11, `out_en` = 1, `ready` = 0. The state returns to Normal, with `ready` = 1, exactly SLEEP_CYC+1 edges after the first edge whose target is Normal. SLEEP_CYC = CLK_KHZ*SLEEP_WAKE_US/1000.
- R7: Leaving Nap without a clock halt returns to Normal exactly NAP_WAKE_CYC+1 edges after the first edge whose target is Normal.
- R8: A `clk_halt` pulse while in Nap makes the next Nap recovery also wait for a `dll_lock` pulse. Normal is then reached on the edge after that pulse. A `dll_lock` pulse outside Nap recovery has no effect.
- R9: In Sleep, `csb` high closes the control port (`cfg_accept` = 0), and writes are ignored. After `csb` goes low, a write is accepted only once `csb` has been sampled low on SETUP_CYC edges before the write edge. SETUP_CYC = CLK_KHZ*SETUP_US/1000 and must be at least 2. If `csb` stays low for the whole of Sleep, the port never closes.
- R10: A target of Nap or Sleep during recovery aborts the recovery on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 2 | Decoded three-level mode pin |
| csb | input | 1 | Control-port chip-select level (active low) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| clk_halt | input | 1 | Pulse: sample clock was stopped |
| dll_lock | input | 1 | Pulse: delay-locked loop regained lock |
| out_en | output | 1 | Digital output drivers enabled (0 = high impedance) |
| ready | output | 1 | Recovery complete, data valid |
| cur_mode | output | 2 | Current state code |
| cfg_accept | output | 1 | Control port open for writes |

## Verification
A pin change reaches `cur_mode` on the first edge after it is driven. A register write reaches `cur_mode` one edge later than a pin change, because the override register sits in between. `ready` rises SLEEP_CYC+1 or NAP_WAKE_CYC+1 edges after the edge that first saw a Normal target. The bench drives inputs on falling edges and counts rising edges from the one that captures the stimulus. It samples on the falling edge just before and just after each due edge, so it catches both an early and a late change. For the chip-select setup window, it issues the same write on the last rejected edge and then on the first accepted edge. Settled-state checks in the random phase wait longer than the longest recovery before comparing.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_NAP   = 2'b01,
        MODE_SLEEP = 2'b10
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_NAP,
        ST_SLEEP,
        ST_WAKE_NAP,
        ST_WAKE_SLP
    } pwr_state_e;

    typedef struct packed {
        logic      valid;
        pwr_mode_e mode;
    } mode_req_t;

    localparam int FIELD_LSB = 1;
    localparam int FIELD_MSB = 3;

    function automatic pwr_mode_e pin_decode(input logic [1:0] pin);
        case (pin)
            2'b01:   return MODE_NAP;
            2'b10:   return MODE_SLEEP;
            default: return MODE_RUN;
        endcase
    endfunction

    function automatic mode_req_t field_decode(input logic [2:0] f);
        mode_req_t r;
        r.valid = 1'b1;
        r.mode  = MODE_RUN;
        case (f)
            3'b001:  r.mode = MODE_RUN;
            3'b010:  r.mode = MODE_NAP;
            3'b011:  r.mode = MODE_SLEEP;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic pwr_state_e mode_to_state(input pwr_mode_e m);
        case (m)
            MODE_NAP:   return ST_NAP;
            MODE_SLEEP: return ST_SLEEP;
            default:    return ST_RUN;
        endcase
    endfunction

    function automatic logic [1:0] state_code(input pwr_state_e s);
        case (s)
            ST_RUN:   return 2'b00;
            ST_NAP:   return 2'b01;
            ST_SLEEP: return 2'b10;
            default:  return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == limit);

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (!clr && en && done) |=> $stable(cnt)); // R6

endmodule

// File: rtl/pwrseq_override.sv
module pwrseq_override
    import pwrseq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_ADDR = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              port_open,
    input  pwr_mode_e         pin_mode,
    output pwr_mode_e         target
);

    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

    logic      ovr;
    pwr_mode_e sw_mode;
    mode_req_t req;
    logic      hit;
    logic      unused_data_bits;

    assign req = field_decode(wr_data[FIELD_MSB:FIELD_LSB]);
    assign hit = wr_en && port_open && (wr_addr == REG_A) && req.valid;
    assign unused_data_bits = ^{wr_data[DATA_W-1:FIELD_MSB+1], wr_data[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr     <= 1'b0;
            sw_mode <= MODE_RUN;
        end else if (hit) begin
            ovr     <= 1'b1;
            sw_mode <= req.mode;
        end
    end

    assign target = ovr ? sw_mode : pin_mode;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr); // R4

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != REG_A) |=> ($stable(ovr) && $stable(sw_mode))); // R5

    AST_CLOSED_PORT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !port_open) |=> ($stable(ovr) && $stable(sw_mode))); // R9

endmodule

// File: rtl/pwrseq_port_gate.sv
module pwrseq_port_gate #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_sleep,
    input  logic             csb,
    input  logic [CNT_W-1:0] setup_lim,
    output logic             port_open
);

    logic blocked;
    logic tmr_done;

    pwrseq_delay #(.CNT_W(CNT_W)) u_setup (
        .clk   (clk),
        .rst   (rst),
        .clr   (csb || !blocked),
        .en    (blocked && !csb),
        .limit (setup_lim),
        .done  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !in_sleep) begin
            blocked <= 1'b0;
        end else if (csb) begin
            blocked <= 1'b1;
        end else if (blocked && tmr_done) begin
            blocked <= 1'b0;
        end
    end

    assign port_open = !blocked;

    AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (in_sleep && csb) |=> !port_open); // R9

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pwr_mode_e        pin_mode,
    input  pwr_mode_e        target,
    input  logic             clk_halt,
    input  logic             dll_lock,
    input  logic [CNT_W-1:0] nap_lim,
    input  logic [CNT_W-1:0] slp_lim,
    output pwr_state_e       state
);

    pwr_state_e state_nx;
    logic       waking;
    logic       tmr_done;
    logic       relock;
    logic       locked;

    assign waking = (state == ST_WAKE_NAP) || (state == ST_WAKE_SLP);

    pwrseq_delay #(.CNT_W(CNT_W)) u_wake (
        .clk   (clk),
        .rst   (rst),
        .clr   (!waking),
        .en    (waking),
        .limit ((state == ST_WAKE_SLP) ? slp_lim : nap_lim),
        .done  (tmr_done)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN: begin
                if (target != MODE_RUN) state_nx = mode_to_state(target);
            end
            ST_NAP: begin
                if (target == MODE_SLEEP)    state_nx = ST_SLEEP;
                else if (target == MODE_RUN) state_nx = ST_WAKE_NAP;
            end
            ST_SLEEP: begin
                if (target == MODE_NAP)      state_nx = ST_NAP;
                else if (target == MODE_RUN) state_nx = ST_WAKE_SLP;
            end
            ST_WAKE_NAP: begin
                if (target != MODE_RUN)                   state_nx = mode_to_state(target);
                else if (tmr_done && (!relock || locked)) state_nx = ST_RUN;
            end
            ST_WAKE_SLP: begin
                if (target != MODE_RUN) state_nx = mode_to_state(target);
                else if (tmr_done)      state_nx = ST_RUN;
            end
            default: state_nx = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= mode_to_state(pin_mode);
            relock <= 1'b0;
            locked <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_NAP && clk_halt) begin
                relock <= 1'b1;
            end else if (state == ST_RUN || state == ST_SLEEP) begin
                relock <= 1'b0;
            end
            locked <= (state == ST_WAKE_NAP) && (locked || dll_lock);
        end
    end

    AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && target == MODE_SLEEP) |=> (state == ST_SLEEP)); // R2

    AST_SLEEP_MIN_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE_SLP && !tmr_done) |=> (state != ST_RUN)); // R6

    AST_RELOCK_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE_NAP && relock && !locked) |=> (state != ST_RUN)); // R8

    AST_ABORT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (waking && target == MODE_NAP) |=> (state == ST_NAP)); // R10

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int CLK_KHZ       = 250000,
    parameter int SLEEP_WAKE_US = 1000,
    parameter int SETUP_US      = 150,
    parameter int NAP_WAKE_CYC  = 64,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int REG_ADDR      = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_pin,
    input  logic              csb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clk_halt,
    input  logic              dll_lock,
    output logic              out_en,
    output logic              ready,
    output logic [1:0]        cur_mode,
    output logic              cfg_accept
);

    localparam int SLP_CYC   = CLK_KHZ * SLEEP_WAKE_US / 1000;
    localparam int SETUP_CYC = CLK_KHZ * SETUP_US / 1000;
    localparam int MAX_A     = (SLP_CYC > SETUP_CYC) ? SLP_CYC : SETUP_CYC;
    localparam int MAX_CYC   = (MAX_A > NAP_WAKE_CYC) ? MAX_A : NAP_WAKE_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SLP_LIM   = CNT_W'(SLP_CYC);
    localparam logic [CNT_W-1:0] NAP_LIM   = CNT_W'(NAP_WAKE_CYC);
    localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_CYC - 1);

    pwr_mode_e  pin_mode;
    pwr_mode_e  target;
    pwr_state_e state;
    logic       port_open;

    assign pin_mode = pin_decode(mode_pin);

    pwrseq_port_gate #(.CNT_W(CNT_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .in_sleep  (state == ST_SLEEP),
        .csb       (csb),
        .setup_lim (SETUP_LIM),
        .port_open (port_open)
    );

    pwrseq_override #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_ovr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .port_open (port_open),
        .pin_mode  (pin_mode),
        .target    (target)
    );

    pwrseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pin_mode (pin_mode),
        .target   (target),
        .clk_halt (clk_halt),
        .dll_lock (dll_lock),
        .nap_lim  (NAP_LIM),
        .slp_lim  (SLP_LIM),
        .state    (state)
    );

    assign cur_mode   = state_code(state);
    assign out_en     = (state != ST_NAP) && (state != ST_SLEEP);
    assign ready      = (state == ST_RUN);
    assign cfg_accept = port_open;

    AST_RDY_FROM_WAKE: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && !$past(rst)) |-> ($past(cur_mode) == 2'b11)); // R6

endmodule

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 100;
    localparam int SLP        = CLK_KHZ * 1000 / 1000;
    localparam int SETUP      = CLK_KHZ * 150 / 1000;
    localparam int NAPW       = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_pin;
    logic       csb;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       clk_halt;
    logic       dll_lock;
    logic       out_en;
    logic       ready;
    logic [1:0] cur_mode;
    logic       cfg_accept;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_top #(
        .CLK_KHZ       (CLK_KHZ),
        .SLEEP_WAKE_US (1000),
        .SETUP_US      (150),
        .NAP_WAKE_CYC  (NAPW)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .mode_pin   (mode_pin),
        .csb        (csb),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .clk_halt   (clk_halt),
        .dll_lock   (dll_lock),
        .out_en     (out_en),
        .ready      (ready),
        .cur_mode   (cur_mode),
        .cfg_accept (cfg_accept)
    );

    function automatic logic [1:0] settled_code(input logic [1:0] p);
        return (p == 2'b01 || p == 2'b10) ? p : 2'b00;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [1:0] m,
                             input logic rdy, input logic oe);
        chk({tag, " mode"},   int'(cur_mode), int'(m));
        chk({tag, " ready"},  int'(ready),    int'(rdy));
        chk({tag, " out_en"}, int'(out_en),   int'(oe));
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; mode_pin = 2'b10; csb = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; clk_halt = 1'b0; dll_lock = 1'b0;
        @(negedge clk);
        tick(3);
        rst = 1'b0;
        chk_state("R1 reset pin sleep", 2'b10, 1'b0, 1'b0);
        rst = 1'b1; mode_pin = 2'b00;
        tick(3);
        rst = 1'b0;
        chk_state("R1 reset pin normal", 2'b00, 1'b1, 1'b1);
        chk("R1 cfg_accept", int'(cfg_accept), 1);

        // R2 entry to Nap
        mode_pin = 2'b01;
        tick(1);
        chk_state("R2 enter nap", 2'b01, 1'b0, 1'b0);

        // R7 nap recovery timing
        mode_pin = 2'b00;
        tick(1);
        chk_state("R7 nap recovering", 2'b11, 1'b0, 1'b1);
        tick(NAPW);
        chk_state("R7 nap last low", 2'b11, 1'b0, 1'b1);
        tick(1);
        chk_state("R7 nap done", 2'b00, 1'b1, 1'b1);

        // R3 direct switching
        mode_pin = 2'b10;
        tick(1);
        chk_state("R2 enter sleep", 2'b10, 1'b0, 1'b0);
        mode_pin = 2'b01;
        tick(1);
        chk_state("R3 sleep to nap", 2'b01, 1'b0, 1'b0);
        mode_pin = 2'b10;
        tick(1);
        chk_state("R3 nap to sleep", 2'b10, 1'b0, 1'b0);
        mode_pin = 2'b01;
        tick(1);

        // R8 clock halt in nap, lock strobe outside recovery ignored
        clk_halt = 1'b1; tick(1); clk_halt = 1'b0;
        dll_lock = 1'b1; tick(1); dll_lock = 1'b0;
        mode_pin = 2'b00;
        tick(1);
        chk("R8 recovering", int'(cur_mode), 3);
        tick(NAPW + 5);
        chk_state("R8 waits for lock", 2'b11, 1'b0, 1'b1);
        dll_lock = 1'b1; tick(1); dll_lock = 1'b0;
        chk("R8 one edge after strobe", int'(cur_mode), 3);
        tick(1);
        chk_state("R8 relocked", 2'b00, 1'b1, 1'b1);

        // R6 pin-driven sleep recovery, csb high closes port (R9)
        csb = 1'b1;
        mode_pin = 2'b10;
        tick(2);
        chk("R9 port closed in sleep", int'(cfg_accept), 0);
        mode_pin = 2'b00;
        tick(1);
        chk_state("R6 sleep recovering", 2'b11, 1'b0, 1'b1);
        tick(SLP);
        chk("R6 last low", int'(ready), 0);
        tick(1);
        chk_state("R6 sleep done", 2'b00, 1'b1, 1'b1);

        // R9 setup window and R4 write wake
        mode_pin = 2'b10;
        tick(3);
        wr(8'd25, 8'b0000_0010);
        tick(2);
        chk("R9 write ignored csb high", int'(cur_mode), 2);
        csb = 1'b0;
        repeat (SETUP - 1) @(posedge clk);
        @(negedge clk);
        wr(8'd25, 8'b0000_0010);
        chk("R9 early write rejected", int'(cur_mode), 2);
        chk("R9 port reopened", int'(cfg_accept), 1);
        wr(8'd25, 8'b0000_0011);
        chk("R4 one edge after write", int'(cur_mode), 2);
        tick(1);
        chk("R4 write wakes", int'(cur_mode), 3);
        tick(SLP);
        chk("R6 write wake last low", int'(ready), 0);
        tick(1);
        chk_state("R6 write wake done", 2'b00, 1'b1, 1'b1);

        // R4 sticky override, R5 ignored writes
        mode_pin = 2'b01;
        tick(3);
        chk_state("R4 pin ignored", 2'b00, 1'b1, 1'b1);
        wr(8'd24, 8'b0000_0100);
        tick(2);
        chk("R5 other address", int'(cur_mode), 0);
        wr(8'd25, 8'b0000_0001);
        tick(2);
        chk("R5 field 000", int'(cur_mode), 0);
        wr(8'd25, 8'b0000_1000);
        tick(2);
        chk("R5 field 100", int'(cur_mode), 0);
        wr(8'd25, 8'b0000_0100);
        tick(1);
        chk_state("R4 write nap", 2'b01, 1'b0, 1'b0);
        wr(8'd25, 8'b0000_0110);
        tick(3);
        chk_state("R4 write sleep", 2'b10, 1'b0, 1'b0);
        chk("R9 csb low keeps port open", int'(cfg_accept), 1);
        wr(8'd25, 8'b0000_0010);
        tick(1);
        chk("R9 immediate accept", int'(cur_mode), 3);
        wr(8'd25, 8'b0000_0100);
        chk("R10 before abort", int'(cur_mode), 3);
        tick(1);
        chk_state("R10 abort to nap", 2'b01, 1'b0, 1'b0);

        // random pin patterns and stray writes
        rst = 1'b1; mode_pin = 2'b00;
        tick(2);
        rst = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic [1:0] p;
            logic [1:0] e;
            p = 2'($urandom_range(0, 3));
            e = settled_code(p);
            mode_pin = p;
            tick(2);
            wr(8'($urandom_range(26, 255)), 8'($urandom_range(0, 255)));
            tick(SLP + 4);
            chk_state("R2 R5 random settle", e, (e == 2'b00), (e == 2'b00));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule